// File: doc/BRIEF.md
# Program Status Poll Responder

This block forms the byte that a flash memory model returns to the host on a read while an internal program cycle is running. The host can find out when the cycle has finished in two ways. It can read the address it last wrote and compare the top bit against the value it wrote, because the top bit reads back inverted until the cycle ends. It can also read twice and compare the second-highest bit, because that bit changes on every read access while the cycle runs.

When the busy flag drops, every read returns true array data again and the host may start a new operation. The host may begin polling at any point in the cycle.

The surrounding model supplies the busy flag, the last loaded byte and its address, the array read data for the current read address, and one read strobe. The read strobe is high while a read access is active. The model combines chip enable and output enable into this strobe, so a pulse on either one counts as a new access. The block captures the reply on the rising edge of the strobe and holds it in a register until the next access.

Top module: `poll_status_responder`

## Requirements
- R1: After synchronous reset, `rd_data` is all zeros.
- R2: A read access is the clock edge at which `rd_strobe` is sampled high after it was sampled low on the previous edge. `rd_data` is updated only at such an edge. It holds its value while the strobe stays high, while it is low, and while other inputs change.
- R3: When `busy` is low at a read access, `rd_data` equals `array_rdata`, all bits.
- R4: When `busy` is high at a read access and `rd_addr` equals `last_addr`, bit DATA_W-1 of `rd_data` is the inverse of bit DATA_W-1 of `last_data`.
- R5: When `busy` is high at a read access and `rd_addr` differs from `last_addr`, bit DATA_W-1 of `rd_data` equals bit DATA_W-1 of `last_data`.
- R6: When `busy` is high at a read access, bits DATA_W-3 down to 0 of `rd_data` equal those bits of `last_data`, and `array_rdata` has no effect.
- R7: When `busy` is high at a read access, bit DATA_W-2 of `rd_data` is the inverse of the value it had at the previous busy read access. The value at the first busy read is not defined. Idle reads in between do not change this toggle state.
- R8: Holding `rd_strobe` high for many cycles while busy counts as one access. The toggle bit does not advance again until the strobe has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal program cycle in progress |
| last_addr | input | ADDR_W | Address of the last loaded byte |
| last_data | input | DATA_W | Value of the last loaded byte |
| rd_addr | input | ADDR_W | Current read address |
| array_rdata | input | DATA_W | Array data at `rd_addr` |
| rd_strobe | input | 1 | Read access active (combined chip and output enable) |
| rd_data | output | DATA_W | Registered byte to drive on the bus |

## Verification
Errors in the edge detector or the output register show up at the first read access. A reply can appear one edge late. It can also change while the strobe is held, or go on changing after the strobe is released.

A bad toggle flop shows up at the second busy read. There bit DATA_W-2 either repeats its old value or advances more than once during a long strobe.

A wrong source select shows up on every read as array data leaking into a busy reply, or as status leaking into an idle reply. Sweeping every last-byte value, with both a matching and a non-matching address, exposes any swapped or inverted bit within one pass.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [0:0] {
    SRC_ARRAY = 1'b0,
    SRC_STATUS = 1'b1
  } reply_src_e;
endpackage

// File: rtl/poll_strobe_edge.sv
module poll_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;

  // A detected access must be followed by a cycle without a new one while the strobe stays high
  assert_single_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (rise && strobe) |=> !rise || !strobe);
endmodule

// File: rtl/poll_toggle.sv
module poll_toggle (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic tog_q,
  output logic tog_next
);
  assign tog_next = advance ? ~tog_q : tog_q;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= 1'b0;
    else     tog_q <= tog_next;
  end

  assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (rst)
    advance |=> (tog_q != $past(tog_q)));
  assert_toggle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(tog_q));
endmodule

// File: rtl/poll_byte_mux.sv
module poll_byte_mux #(
  parameter int DATA_W = 8
) (
  input  poll_pkg::reply_src_e src,
  input  logic                 addr_hit,
  input  logic                 tog,
  input  logic [DATA_W-1:0]    last_data,
  input  logic [DATA_W-1:0]    array_rdata,
  output logic [DATA_W-1:0]    reply
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_byte;

  always_comb begin
    status_byte           = last_data;
    status_byte[POLL_BIT] = last_data[POLL_BIT] ^ addr_hit;
    status_byte[TOG_BIT]  = tog;
  end

  always_comb begin
    unique case (src)
      poll_pkg::SRC_STATUS: reply = status_byte;
      default:              reply = array_rdata;
    endcase
  end
endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;
  localparam int LOW_W    = DATA_W - 2;

  logic                 access;
  logic                 tog_q;
  logic                 tog_next;
  logic                 addr_hit;
  poll_pkg::reply_src_e src;
  logic [DATA_W-1:0]    reply;
  logic [DATA_W-1:0]    rd_data_q;

  poll_strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (rd_strobe),
    .rise   (access)
  );

  poll_toggle u_tog (
    .clk      (clk),
    .rst      (rst),
    .advance  (access & busy),
    .tog_q    (tog_q),
    .tog_next (tog_next)
  );

  assign addr_hit = (rd_addr == last_addr);
  assign src      = busy ? poll_pkg::SRC_STATUS : poll_pkg::SRC_ARRAY;

  poll_byte_mux #(.DATA_W(DATA_W)) u_mux (
    .src         (src),
    .addr_hit    (addr_hit),
    .tog         (tog_next),
    .last_data   (last_data),
    .array_rdata (array_rdata),
    .reply       (reply)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data_q <= '0;
    else if (access) rd_data_q <= reply;
  end

  assign rd_data = rd_data_q;

  assert_hold_between_reads_R2: assert property (@(posedge clk) disable iff (rst)
    !access |=> $stable(rd_data));
  assert_idle_true_data_R3: assert property (@(posedge clk) disable iff (rst)
    (access && !busy) |=> (rd_data == $past(array_rdata)));
  assert_poll_inverted_R4: assert property (@(posedge clk) disable iff (rst)
    (access && busy && rd_addr == last_addr) |=> (rd_data[POLL_BIT] == !$past(last_data[POLL_BIT])));
  assert_poll_plain_R5: assert property (@(posedge clk) disable iff (rst)
    (access && busy && rd_addr != last_addr) |=> (rd_data[POLL_BIT] == $past(last_data[POLL_BIT])));
  assert_low_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (access && busy) |=> (rd_data[LOW_W-1:0] == $past(last_data[LOW_W-1:0])));
  assert_toggle_out_R7: assert property (@(posedge clk) disable iff (rst)
    (access && busy) |=> (rd_data[TOG_BIT] == tog_q));
endmodule

// File: tb/tb_poll_status_responder.sv
module tb_poll_status_responder;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busy = 1'b0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [DATA_W-1:0] last_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] array_rdata = '0;
  logic              rd_strobe = 1'b0;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic have_prev = 1'b0;
  logic prev_tog = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_status_responder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .busy(busy), .last_addr(last_addr),
    .last_data(last_data), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: strobe rises, reply is registered at the next edge.
  task automatic do_read(input logic [ADDR_W-1:0] a);
    rd_addr = a;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic busy_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] e;
    do_read(a);
    e = last_data;
    e[7] = last_data[7] ^ (a == last_addr);
    check(a == last_addr ? "R4" : "R5", {7'b0, rd_data[7]}, {7'b0, e[7]});
    check("R6", {2'b0, rd_data[5:0]}, {2'b0, e[5:0]});
    if (have_prev) check("R7", {7'b0, rd_data[6]}, {7'b0, ~prev_tog});
    have_prev = 1'b1;
    prev_tog = rd_data[6];
  endtask

  initial begin
    logic [DATA_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1", rd_data, '0);
    rst = 1'b0;
    @(negedge clk);

    // R3: idle reads return array data, all values
    for (int v = 0; v < 256; v++) begin
      array_rdata = v[7:0];
      do_read(v[3:0]);
      check("R3", rd_data, v[7:0]);
    end

    // R4/R5/R6/R7: busy sweep of every last byte, hit and miss address
    busy = 1'b1;
    last_addr = 4'h5;
    for (int v = 0; v < 256; v++) begin
      last_data = v[7:0];
      array_rdata = ~v[7:0];
      busy_read(4'h5);
      busy_read(4'hA);
    end

    // R2/R8: strobe held high counts once; inputs changing do not alter reply
    last_data = 8'h3C;
    rd_addr = 4'h5;
    rd_strobe = 1'b1;
    @(negedge clk);
    held = rd_data;
    check("R7", {7'b0, held[6]}, {7'b0, ~prev_tog});
    prev_tog = held[6];
    for (int i = 0; i < 4; i++) begin
      last_data = 8'h81 + i[7:0];
      array_rdata = 8'h11 * i[7:0];
      @(negedge clk);
      check("R8", rd_data, held);
    end
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", rd_data, held);

    // R7: idle reads between busy reads do not disturb toggle state
    busy = 1'b0;
    array_rdata = 8'hE7;
    do_read(4'h5);
    check("R3", rd_data, 8'hE7);
    busy = 1'b1;
    last_data = 8'h3C;
    busy_read(4'h5);

    // R3: return to true data when busy clears
    busy = 1'b0;
    array_rdata = 8'h42;
    do_read(4'h5);
    check("R3", rd_data, 8'h42);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule